// File: doc/BRIEF.md
# Factorial Compute Engine

A small register-mapped accelerator that turns a 32-bit operand into its factorial. Software writes the operand into a single value register. That write starts an iterative multiply loop, and the same register later holds the result. While the loop runs, a busy flag in the status register is high. Software either polls that flag or sets an enable bit so that completion raises a one-cycle interrupt request. The request goes to a separate interrupt-status block.

The host port is a plain single-cycle access bus with a request strobe, a write flag, a byte address, an access size in bytes, write data and registered read data. Every read returns its data with a valid strobe one cycle after the request. Only 4-byte accesses reach the registers. A read of any other size, or of an unmapped offset, returns all ones.

Top module: `fact_engine`

## Requirements
- R1: A 4-byte write to offset 0x08 while idle stores the operand and sets the busy flag. A read of 0x08 while busy returns that operand.
- R2: A read of the status register at offset 0x20 returns the busy flag in bit 0 and the completion-interrupt enable in bit 7. All other bits read 0.
- R3: A write to offset 0x08 while busy is dropped. The running computation and its result are unaffected.
- R4: The result is n·(n−1)·…·1 truncated to 32 bits. Operands 0 and 1 both give 1.
- R5: The loop takes one clock per factor plus one finishing clock, so busy stays high for n+1 cycles after the accepting edge. The result replaces the operand in 0x08 on the same edge that clears busy.
- R6: If the enable bit is set, `irq_o` is high for exactly one cycle, in the first cycle after busy clears.
- R7: Writing status with bit 7 clear disables the completion interrupt. Written bit 0 has no effect on the busy flag.
- R8: An access whose size is not 4 bytes leaves every register unchanged on a write and reads back as all ones.
- R9: `rvalid_o` and `rdata_o` follow a read request by exactly one cycle. A read of an unmapped offset returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| size_i | input | 4 | Access size in bytes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid, one cycle after the request |
| irq_o | output | 1 | Completion interrupt request pulse |

## Verification
The bench issues an operand write in the middle of a running computation. A design that accepted it would return the factorial of the wrong number. Operands 0, 1, 12 and 13 cover the empty product, the trivial product and 32-bit wraparound. A loop that stopped one factor early or late, or that mishandled zero, shows up as a wrong result.

Back-to-back status reads after a write pin the busy window to n+1 cycles. Interrupt pulses are counted with the enable set and then cleared, so a missing gate or a stuck request line changes the count. The bench also writes status with bit 0 set, which must not touch the busy flag. Non-4-byte writes and reads check that wrong-size accesses neither store anything nor return register contents.

// File: rtl/fact_pkg.sv
package fact_pkg;
  localparam logic [7:0] OFF_VAL   = 8'h08;
  localparam logic [7:0] OFF_STAT  = 8'h20;
  localparam int         BUSY_BIT  = 0;
  localparam int         IE_BIT    = 7;
  localparam int         ACC_BYTES = 4;
endpackage

// File: rtl/fact_core.sv
module fact_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              busy_o,
  output logic              finish_o,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] cnt_q, acc_q;
  logic              busy_q;

  // last busy cycle: all factors consumed
  assign finish_o = busy_q && (cnt_q == '0);
  assign busy_o   = busy_q;
  assign result_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= operand_i;
      acc_q  <= DATA_W'(1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        acc_q <= acc_q * cnt_q;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fact_regs.sv
module fact_regs
  import fact_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              finish_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              start_o,
  output logic [DATA_W-1:0] val_o,
  output logic              ie_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] val_q, rdata_q, rd_mux;
  logic              ie_q, rvalid_q, irq_q;
  logic              size_ok, wr_val, wr_stat, rd;

  assign size_ok = (size_i == SIZE_W'(ACC_BYTES));
  assign wr_val  = req_i && we_i && size_ok && (addr_i == ADDR_W'(OFF_VAL));
  assign wr_stat = req_i && we_i && size_ok && (addr_i == ADDR_W'(OFF_STAT));
  assign rd      = req_i && !we_i;
  assign start_o = wr_val && !busy_i;

  always_comb begin
    rd_mux = '1;
    if (size_ok) begin
      if (addr_i == ADDR_W'(OFF_VAL)) begin
        rd_mux = val_q;
      end else if (addr_i == ADDR_W'(OFF_STAT)) begin
        rd_mux = '0;
        rd_mux[BUSY_BIT] = busy_i;
        rd_mux[IE_BIT]   = ie_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q    <= '0;
      ie_q     <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (finish_i)     val_q <= result_i;
      else if (start_o) val_q <= wdata_i;
      if (wr_stat) ie_q <= wdata_i[IE_BIT];
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
      irq_q <= finish_i && ie_q;
    end
  end

  assign val_o    = val_q;
  assign ie_o     = ie_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/fact_engine.sv
module fact_engine #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  logic              start, busy, finish, ie;
  logic [DATA_W-1:0] result, val;

  fact_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i, .wdata_i,
    .busy_i(busy), .finish_i(finish), .result_i(result),
    .start_o(start), .val_o(val), .ie_o(ie),
    .rdata_o, .rvalid_o, .irq_o
  );

  fact_core #(.DATA_W(DATA_W)) u_core (
    .clk_i, .rst_ni, .start_i(start), .operand_i(wdata_i),
    .busy_o(busy), .finish_o(finish), .result_o(result)
  );
endmodule

// File: rtl/fact_engine_chk.sv
module fact_engine_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [SIZE_W-1:0] size_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              irq_o,
  input logic              busy,
  input logic              finish,
  input logic              ie,
  input logic [DATA_W-1:0] val
);
  // R1
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(req_i && we_i && addr_i == ADDR_W'(8'h08) && size_i == SIZE_W'(4)));
  // R3
  drop_busy_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !finish) |=> $stable(val));
  // R6
  irq_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && $past(ie)) |-> irq_o);
  // R6
  irq_only_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($fell(busy) && !busy));
  // R8
  bad_size_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i != SIZE_W'(4)) |=> (rvalid_o && rdata_o == '1));
  // R9
  rvalid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));
endmodule

bind fact_engine fact_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i, .rdata_o, .rvalid_o, .irq_o,
  .busy(busy), .finish(finish), .ie(ie), .val(val)
);

// File: tb/fact_engine_tb.sv
module fact_engine_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [3:0]  size_i = 4'd4;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, irq_o;

  int checks = 0, errors = 0, irq_cnt = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  fact_engine u_dut (.*);

  // monitor: compares read data and counts interrupt pulses
  always @(negedge clk_i) begin
    if (rst_ni && irq_o) irq_cnt++;
    if (rst_ni && rvalid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected rvalid act=%h exp=none", rdata_o);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata_o !== e) begin
          errors++;
          $display("FAIL %s act=%h exp=%h", t, rdata_o, e);
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] sz = 4'd4);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d; size_i = sz;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t,
                    input logic [3:0] sz = 4'd4);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; size_i = sz;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) idle();
  endtask

  task automatic check(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", t, act, exp);
    end
  endtask

  task automatic fact_run(input logic [31:0] n, input logic [31:0] e, input string t);
    wr(8'h08, n);
    gap(int'(n) + 4);
    rd(8'h08, e, t);
    gap(2);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(8'h20, 32'h0, "R2 reset status");
    rd(8'h08, 32'h0, "R1 reset value");
    // R1 R3: operand visible while busy, write while busy dropped
    wr(8'h08, 32'd5);
    rd(8'h20, 32'h1, "R2 busy bit");
    rd(8'h08, 32'd5, "R1 operand while busy");
    wr(8'h08, 32'd3);
    gap(8);
    rd(8'h08, 32'd120, "R3 busy write dropped, 5!");
    gap(2);
    // R4 corner operands
    fact_run(32'd0, 32'd1, "R4 0!");
    fact_run(32'd1, 32'd1, "R4 1!");
    fact_run(32'd12, 32'd479001600, "R4 12!");
    fact_run(32'd13, 32'd1932053504, "R4 13! wrap");
    check(irq_cnt == 0, "R7 no irq while disabled", irq_cnt, 0);
    // R6 enable, R5 busy window for n=4
    wr(8'h20, 32'h80);
    rd(8'h20, 32'h80, "R2 ie bit");
    wr(8'h08, 32'd4);
    for (int i = 0; i < 5; i++) rd(8'h20, 32'h81, "R5 busy window");
    rd(8'h20, 32'h80, "R5 busy cleared");
    rd(8'h08, 32'd24, "R5 result at busy clear");
    gap(3);
    check(irq_cnt == 1, "R6 one irq pulse", irq_cnt, 1);
    // R7 disable with bit0 set
    wr(8'h20, 32'h1);
    rd(8'h20, 32'h0, "R7 bit0 no effect, ie cleared");
    fact_run(32'd3, 32'd6, "R4 3!");
    check(irq_cnt == 1, "R7 irq disabled", irq_cnt, 1);
    // R8 size rules, R9 unmapped
    wr(8'h08, 32'd7, 4'd2);
    rd(8'h20, 32'h0, "R8 short write no start");
    rd(8'h08, 32'd6, "R8 short write no store");
    wr(8'h20, 32'h80, 4'd8);
    rd(8'h20, 32'h0, "R8 wide write ignored");
    rd(8'h08, 32'hFFFF_FFFF, "R8 wide read ones", 4'd8);
    rd(8'h10, 32'hFFFF_FFFF, "R9 unmapped read");
    gap(4);
    check(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule